// File: doc/BRIEF.md
# Processor Clock-Control Power-State Sequencer

This block follows a processor through its clock-control power states: Normal, AutoHALT, Stop-Grant, the snoop state entered from halt or grant, Sleep, Deep Sleep and Deeper Sleep. It samples active-low stop-clock, sleep and deep-sleep requests on the bus clock, together with snoop and halt strobes, a response-done strobe for the grant acknowledge cycle, halt-break event lines and the voltage regulator's done indications. It reports the current state as a 3-bit code.

To reach Stop-Grant, the block first raises a request for the grant acknowledge bus cycle. After that cycle's response completes, it waits a fixed number of bus clocks. While in Stop-Grant, a bus-init event is held in a pending flag instead of being acted on. A core reset in that state only produces an initialization pulse. On the way down into the sleep states and back up, the block drives core-voltage lower and raise requests. It also flags a stop-clock release that comes too soon after a sleep release.

Top module: `pwr_clkstate_seq`

## Requirements
- R1: After reset the state code is 0 (Normal), and ack_req, init_pulse, binit_pend, vlower_req, vraise_req and spacing_err are all low.
- R2: The state codes are Normal=0, AutoHALT=1, Stop-Grant=2, Snoop=3, Sleep=4, Deep Sleep=5 and Deeper Sleep=6. A halt_insn strobe sampled in Normal moves the state to 1. In AutoHALT, any break event moves the state to 0 at the next edge. A break event is bus_init, core_reset or any bit of brk_evt.
- R3: When stop_req_n is sampled low in Normal or AutoHALT, ack_req goes high after that edge. It stays high until the edge that samples ack_resp_done. If stop_req_n is sampled high while the request is outstanding, the request is withdrawn and the state is unchanged.
- R4: The state becomes 2 exactly ENTRY_DLY (default 20) edges after the edge that sampled ack_resp_done. It is still the old state one edge earlier.
- R5: bus_init sampled in Stop-Grant sets binit_pend and leaves the state at 2. binit_pend stays set after Stop-Grant is left and clears only at an edge that samples pend_clr.
- R6: core_reset sampled in Stop-Grant makes init_pulse high for the following cycle while the state stays 2.
- R7: When stop_req_n is sampled high in Stop-Grant, the state goes to 1 if Stop-Grant was entered from AutoHALT, and to 0 otherwise.
- R8: snoop_hit sampled in Stop-Grant or AutoHALT moves the state to 3. snoop_done sampled in state 3 returns the state to the one it came from.
- R9: sleep_req_n sampled low in Stop-Grant moves the state to 4. sleep_req_n sampled high in state 4 moves it back to 2. A stop_req_n release during state 4 has no effect.
- R10: Count edges from the edge that samples the sleep release. A stop_req_n release sampled at fewer than SPACE_MIN (default 10) edges sets spacing_err, which stays set until reset. A release sampled at SPACE_MIN or more edges does not set it. The state exits Stop-Grant in both cases.
- R11: deep_req_n sampled low in Sleep moves the state to 5, with vlower_req high. vlow_done moves it to 6. In state 6, deep_req_n sampled high raises vraise_req. vhigh_done returns the state to 5. deep_req_n sampled high in state 5 returns the state to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_n | input | 1 | Stop-clock request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| deep_req_n | input | 1 | Deep-sleep request, active low |
| ack_resp_done | input | 1 | Response phase of the grant acknowledge cycle done |
| halt_insn | input | 1 | Halt instruction strobe |
| snoop_hit | input | 1 | Snoop detected strobe |
| snoop_done | input | 1 | Snoop serviced strobe |
| bus_init | input | 1 | Bus-init event |
| core_reset | input | 1 | Core reset event |
| brk_evt | input | BRK_W | Other halt-break events, one line each |
| vlow_done | input | 1 | Core voltage has been lowered |
| vhigh_done | input | 1 | Core voltage has been raised |
| pend_clr | input | 1 | Clears the pending bus-init flag |
| pstate | output | 3 | Current state code |
| ack_req | output | 1 | Request to issue the grant acknowledge cycle |
| init_pulse | output | 1 | Internal initialization pulse |
| binit_pend | output | 1 | Deferred bus-init pending |
| vlower_req | output | 1 | Request to lower core voltage |
| vraise_req | output | 1 | Request to raise core voltage |
| spacing_err | output | 1 | Stop release came too soon after sleep release |

## Verification
The state register drives pstate directly, so a wrong transition is visible at the port on the edge where it happens. The bench therefore samples one cycle after every stimulus. A wrong entry phase shows as ack_req at the wrong level within one cycle. An off-by-one in the shared counter moves the Stop-Grant entry edge, or moves the boundary between an accepted and a flagged stop release. For this reason the bench probes ENTRY_DLY-1 against ENTRY_DLY edges, and SPACE_MIN-1 against SPACE_MIN edges.

// File: rtl/pwr_clkstate_pkg.sv
package pwr_clkstate_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_AUTOHALT = 3'd1,
    ST_GRANT    = 3'd2,
    ST_SNOOP    = 3'd3,
    ST_SLEEP    = 3'd4,
    ST_DEEP     = 3'd5,
    ST_DEEPER   = 3'd6
  } pstate_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACK  = 2'd1,
    PH_DLY  = 2'd2
  } entry_ph_e;
endpackage

// File: rtl/pwr_sat_counter.sv
module pwr_sat_counter #(
  parameter int MAX_VAL = 20,
  parameter int W       = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (en && cnt_q != W'(MAX_VAL))
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwr_clkstate_fsm.sv
module pwr_clkstate_fsm
  import pwr_clkstate_pkg::*;
#(
  parameter int ENTRY_DLY = 20,
  parameter int SPACE_MIN = 10,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req_n,
  input  logic             sleep_req_n,
  input  logic             deep_req_n,
  input  logic             ack_resp_done,
  input  logic             halt_insn,
  input  logic             snoop_hit,
  input  logic             snoop_done,
  input  logic             bus_init,
  input  logic             core_reset,
  input  logic             brk_any,
  input  logic             vlow_done,
  input  logic             vhigh_done,
  input  logic             pend_clr,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic [2:0]       state_o,
  output logic             ack_req,
  output logic             init_pulse,
  output logic             binit_pend,
  output logic             vlower_req,
  output logic             vraise_req,
  output logic             spacing_err
);
  pstate_e   st_q, nxt;
  entry_ph_e ph_q, ph_n;
  logic from_halt_q, from_halt_n;
  logic snp_grant_q, snp_grant_n;
  logic spc_act_q, spc_act_n;
  logic init_q, pend_q, err_q, vlow_q, vraise_q;
  logic entry_go, err_set;

  always_comb begin
    nxt         = st_q;
    ph_n        = ph_q;
    from_halt_n = from_halt_q;
    snp_grant_n = snp_grant_q;
    spc_act_n   = spc_act_q;
    cnt_clr     = 1'b0;
    cnt_en      = 1'b0;
    entry_go    = 1'b0;
    err_set     = 1'b0;

    // acknowledge handshake and fixed delay, shared by Normal and AutoHALT
    if (st_q == ST_NORMAL || st_q == ST_AUTOHALT) begin
      if (stop_req_n) begin
        ph_n = PH_IDLE;
      end else begin
        case (ph_q)
          PH_IDLE: ph_n = PH_ACK;
          PH_ACK: if (ack_resp_done) begin
            ph_n    = PH_DLY;
            cnt_clr = 1'b1;
          end
          default: begin
            cnt_en = 1'b1;
            if (cnt == CNT_W'(ENTRY_DLY - 1)) begin
              ph_n     = PH_IDLE;
              entry_go = 1'b1;
            end
          end
        endcase
      end
    end

    case (st_q)
      ST_NORMAL: begin
        if (entry_go) begin
          nxt         = ST_GRANT;
          from_halt_n = 1'b0;
        end else if (halt_insn) begin
          nxt = ST_AUTOHALT;
        end
      end
      ST_AUTOHALT: begin
        if (brk_any) begin
          nxt = ST_NORMAL;
        end else if (entry_go) begin
          nxt         = ST_GRANT;
          from_halt_n = 1'b1;
        end else if (snoop_hit) begin
          nxt         = ST_SNOOP;
          snp_grant_n = 1'b0;
        end
      end
      ST_GRANT: begin
        cnt_en = 1'b1;
        if (stop_req_n) begin
          nxt       = from_halt_q ? ST_AUTOHALT : ST_NORMAL;
          err_set   = spc_act_q && (cnt < CNT_W'(SPACE_MIN - 1));
          spc_act_n = 1'b0;
        end else if (!sleep_req_n) begin
          nxt       = ST_SLEEP;
          spc_act_n = 1'b0;
        end else if (snoop_hit) begin
          nxt         = ST_SNOOP;
          snp_grant_n = 1'b1;
        end
      end
      ST_SNOOP: begin
        if (snoop_done) nxt = snp_grant_q ? ST_GRANT : ST_AUTOHALT;
      end
      ST_SLEEP: begin
        if (sleep_req_n) begin
          nxt       = ST_GRANT;
          spc_act_n = 1'b1;
          cnt_clr   = 1'b1;
        end else if (!deep_req_n) begin
          nxt = ST_DEEP;
        end
      end
      ST_DEEP: begin
        if (deep_req_n)     nxt = ST_SLEEP;
        else if (vlow_done) nxt = ST_DEEPER;
      end
      ST_DEEPER: begin
        if (vhigh_done) nxt = ST_DEEP;
      end
      default: begin
        nxt  = ST_NORMAL;
        ph_n = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_NORMAL;
      ph_q        <= PH_IDLE;
      from_halt_q <= 1'b0;
      snp_grant_q <= 1'b0;
      spc_act_q   <= 1'b0;
      init_q      <= 1'b0;
      pend_q      <= 1'b0;
      err_q       <= 1'b0;
      vlow_q      <= 1'b0;
      vraise_q    <= 1'b0;
    end else begin
      st_q        <= nxt;
      ph_q        <= ph_n;
      from_halt_q <= from_halt_n;
      snp_grant_q <= snp_grant_n;
      spc_act_q   <= spc_act_n;
      init_q      <= (st_q == ST_GRANT) && core_reset;
      if (st_q == ST_GRANT && bus_init) pend_q <= 1'b1;
      else if (pend_clr)                pend_q <= 1'b0;
      err_q       <= err_q | err_set;
      if (nxt != ST_DEEP)         vlow_q <= 1'b0;
      else if (st_q == ST_SLEEP)  vlow_q <= 1'b1;
      if (nxt != ST_DEEPER)                         vraise_q <= 1'b0;
      else if (st_q == ST_DEEPER && deep_req_n)     vraise_q <= 1'b1;
    end
  end

  assign state_o     = st_q;
  assign ack_req     = (ph_q == PH_ACK);
  assign init_pulse  = init_q;
  assign binit_pend  = pend_q;
  assign vlower_req  = vlow_q;
  assign vraise_req  = vraise_q;
  assign spacing_err = err_q;

  // R4
  grant_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GRANT && ($past(st_q) == ST_NORMAL || $past(st_q) == ST_AUTOHALT))
      |-> $past(ph_q) == PH_DLY);

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (binit_pend && !pend_clr) |=> binit_pend);

  // R6
  reset_keeps_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_GRANT && core_reset && !stop_req_n && sleep_req_n && !snoop_hit)
      |=> st_q == ST_GRANT);

  // R8
  snoop_return_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SNOOP && snoop_done) |=> (st_q == ST_GRANT || st_q == ST_AUTOHALT));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    spacing_err |=> spacing_err);

  // R11
  deeper_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DEEPER && $past(st_q) != ST_DEEPER) |-> $past(st_q) == ST_DEEP);
endmodule

// File: rtl/pwr_clkstate_seq.sv
module pwr_clkstate_seq #(
  parameter int ENTRY_DLY = 20,
  parameter int SPACE_MIN = 10,
  parameter int BRK_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req_n,
  input  logic             sleep_req_n,
  input  logic             deep_req_n,
  input  logic             ack_resp_done,
  input  logic             halt_insn,
  input  logic             snoop_hit,
  input  logic             snoop_done,
  input  logic             bus_init,
  input  logic             core_reset,
  input  logic [BRK_W-1:0] brk_evt,
  input  logic             vlow_done,
  input  logic             vhigh_done,
  input  logic             pend_clr,
  output logic [2:0]       pstate,
  output logic             ack_req,
  output logic             init_pulse,
  output logic             binit_pend,
  output logic             vlower_req,
  output logic             vraise_req,
  output logic             spacing_err
);
  localparam int CNT_MAX = (ENTRY_DLY > SPACE_MIN) ? ENTRY_DLY : SPACE_MIN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic cnt_clr, cnt_en;
  logic brk_any;

  assign brk_any = (|brk_evt) | bus_init | core_reset;

  pwr_sat_counter #(.MAX_VAL(CNT_MAX), .W(CNT_W)) u_ctr (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .en  (cnt_en),
    .cnt (cnt)
  );

  pwr_clkstate_fsm #(.ENTRY_DLY(ENTRY_DLY), .SPACE_MIN(SPACE_MIN), .CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .stop_req_n    (stop_req_n),
    .sleep_req_n   (sleep_req_n),
    .deep_req_n    (deep_req_n),
    .ack_resp_done (ack_resp_done),
    .halt_insn     (halt_insn),
    .snoop_hit     (snoop_hit),
    .snoop_done    (snoop_done),
    .bus_init      (bus_init),
    .core_reset    (core_reset),
    .brk_any       (brk_any),
    .vlow_done     (vlow_done),
    .vhigh_done    (vhigh_done),
    .pend_clr      (pend_clr),
    .cnt           (cnt),
    .cnt_clr       (cnt_clr),
    .cnt_en        (cnt_en),
    .state_o       (pstate),
    .ack_req       (ack_req),
    .init_pulse    (init_pulse),
    .binit_pend    (binit_pend),
    .vlower_req    (vlower_req),
    .vraise_req    (vraise_req),
    .spacing_err   (spacing_err)
  );
endmodule

// File: tb/pwr_clkstate_seq_bench.sv
module pwr_clkstate_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BRK_W      = 7;
  localparam int ENTRY      = 20;
  localparam int SPACE      = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_req_n = 1'b1, sleep_req_n = 1'b1, deep_req_n = 1'b1;
  logic ack_resp_done = 1'b0, halt_insn = 1'b0, snoop_hit = 1'b0, snoop_done = 1'b0;
  logic bus_init = 1'b0, core_reset = 1'b0, vlow_done = 1'b0, vhigh_done = 1'b0, pend_clr = 1'b0;
  logic [BRK_W-1:0] brk_evt = '0;
  logic [2:0] pstate;
  logic ack_req, init_pulse, binit_pend, vlower_req, vraise_req, spacing_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_clkstate_seq #(.ENTRY_DLY(ENTRY), .SPACE_MIN(SPACE), .BRK_W(BRK_W)) u_pwr_clkstate_seq (
    .clk(clk), .rst(rst), .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n),
    .deep_req_n(deep_req_n), .ack_resp_done(ack_resp_done), .halt_insn(halt_insn),
    .snoop_hit(snoop_hit), .snoop_done(snoop_done), .bus_init(bus_init),
    .core_reset(core_reset), .brk_evt(brk_evt), .vlow_done(vlow_done),
    .vhigh_done(vhigh_done), .pend_clr(pend_clr), .pstate(pstate), .ack_req(ack_req),
    .init_pulse(init_pulse), .binit_pend(binit_pend), .vlower_req(vlower_req),
    .vraise_req(vraise_req), .spacing_err(spacing_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    stop_req_n = 1'b1; sleep_req_n = 1'b1; deep_req_n = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic enter_grant();
    stop_req_n = 1'b0;
    tick(1);
    ack_resp_done = 1'b1;
    tick(1);
    ack_resp_done = 1'b0;
    tick(ENTRY);
  endtask

  task automatic t_reset();
    check("R1 state", pstate, 0);
    check("R1 ack_req", ack_req, 0);
    check("R1 init_pulse", init_pulse, 0);
    check("R1 binit_pend", binit_pend, 0);
    check("R1 vlower_req", vlower_req, 0);
    check("R1 vraise_req", vraise_req, 0);
    check("R1 spacing_err", spacing_err, 0);
  endtask

  task automatic t_halt_break();
    halt_insn = 1'b1; tick(1); halt_insn = 1'b0;
    check("R2 halt to AutoHALT", pstate, 1);
    brk_evt[3] = 1'b1; tick(1); brk_evt = '0;
    check("R2 break line to Normal", pstate, 0);
    halt_insn = 1'b1; tick(1); halt_insn = 1'b0;
    bus_init = 1'b1; tick(1); bus_init = 1'b0;
    check("R2 bus_init break", pstate, 0);
    halt_insn = 1'b1; tick(1); halt_insn = 1'b0;
    core_reset = 1'b1; tick(1); core_reset = 1'b0;
    check("R2 core_reset break", pstate, 0);
    check("R2 no init pulse outside grant", init_pulse, 0);
  endtask

  task automatic t_abort();
    stop_req_n = 1'b0; tick(1);
    check("R3 ack raised", ack_req, 1);
    stop_req_n = 1'b1; tick(1);
    check("R3 ack withdrawn", ack_req, 0);
    check("R3 state kept", pstate, 0);
  endtask

  task automatic t_entry();
    stop_req_n = 1'b0; tick(1);
    check("R3 ack after stop", ack_req, 1);
    tick(2);
    check("R3 ack held", ack_req, 1);
    ack_resp_done = 1'b1; tick(1); ack_resp_done = 1'b0;
    check("R3 ack dropped", ack_req, 0);
    tick(ENTRY - 1);
    check("R4 not yet grant", pstate, 0);
    tick(1);
    check("R4 grant on time", pstate, 2);
  endtask

  task automatic t_grant_events();
    bus_init = 1'b1; tick(1); bus_init = 1'b0;
    check("R5 pend set", binit_pend, 1);
    check("R5 state kept", pstate, 2);
    core_reset = 1'b1; tick(1); core_reset = 1'b0;
    check("R6 init pulse", init_pulse, 1);
    check("R6 state kept", pstate, 2);
    tick(1);
    check("R6 pulse ends", init_pulse, 0);
    stop_req_n = 1'b1; tick(1);
    check("R7 back to Normal", pstate, 0);
    check("R5 pend survives exit", binit_pend, 1);
    pend_clr = 1'b1; tick(1); pend_clr = 1'b0;
    check("R5 pend cleared", binit_pend, 0);
  endtask

  task automatic t_halt_grant_snoop();
    halt_insn = 1'b1; tick(1); halt_insn = 1'b0;
    enter_grant();
    check("R4 grant from AutoHALT", pstate, 2);
    snoop_hit = 1'b1; tick(1); snoop_hit = 1'b0;
    check("R8 snoop from grant", pstate, 3);
    snoop_done = 1'b1; tick(1); snoop_done = 1'b0;
    check("R8 back to grant", pstate, 2);
    stop_req_n = 1'b1; tick(1);
    check("R7 back to AutoHALT", pstate, 1);
    snoop_hit = 1'b1; tick(1); snoop_hit = 1'b0;
    check("R8 snoop from AutoHALT", pstate, 3);
    snoop_done = 1'b1; tick(1); snoop_done = 1'b0;
    check("R8 back to AutoHALT", pstate, 1);
    brk_evt[0] = 1'b1; tick(1); brk_evt = '0;
    check("R2 break after snoop", pstate, 0);
  endtask

  task automatic t_sleep_chain();
    enter_grant();
    sleep_req_n = 1'b0; tick(1);
    check("R9 to Sleep", pstate, 4);
    stop_req_n = 1'b1; tick(1);
    check("R9 stop release ignored", pstate, 4);
    stop_req_n = 1'b0;
    deep_req_n = 1'b0; tick(1);
    check("R11 to Deep", pstate, 5);
    check("R11 lower req", vlower_req, 1);
    vlow_done = 1'b1; tick(1); vlow_done = 1'b0;
    check("R11 to Deeper", pstate, 6);
    check("R11 lower req ends", vlower_req, 0);
    check("R11 no raise yet", vraise_req, 0);
    deep_req_n = 1'b1; tick(1);
    check("R11 raise req", vraise_req, 1);
    check("R11 stays Deeper", pstate, 6);
    vhigh_done = 1'b1; tick(1); vhigh_done = 1'b0;
    check("R11 back to Deep", pstate, 5);
    check("R11 raise ends", vraise_req, 0);
    tick(1);
    check("R11 back to Sleep", pstate, 4);
    sleep_req_n = 1'b1; tick(1);
    check("R9 back to grant", pstate, 2);
    tick(SPACE - 1);
    stop_req_n = 1'b1; tick(1);
    check("R10 legal release exits", pstate, 0);
    check("R10 no error at limit", spacing_err, 0);
  endtask

  task automatic t_spacing_bad();
    enter_grant();
    sleep_req_n = 1'b0; tick(1);
    sleep_req_n = 1'b1; tick(1);
    tick(SPACE - 2);
    stop_req_n = 1'b1; tick(1);
    check("R10 early release exits", pstate, 0);
    check("R10 error flagged", spacing_err, 1);
    tick(3);
    check("R10 error sticky", spacing_err, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_halt_break();
    t_abort();
    t_entry();
    t_grant_events();
    t_halt_grant_snoop();
    t_sleep_chain();
    t_spacing_bad();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule